// File: doc/BRIEF.md
# Error-integrating dead-time compensator

This block sits between a PWM modulator and the dead-time insertion stage of one inverter leg. It takes the commanded switching waveform and a digital signal from an output-voltage detector that shows when the leg actually switched. A signed error counter integrates the difference between the two. It moves up for every clock in which the command is high and the leg output is low, and down for every clock in which the command is low and the leg output is high. With a constant dc-link voltage, this count is the running volt-second error of the leg.

The compensated command sent to dead-time insertion copies each command edge at once, unless the integrated error says the leg still owes or holds area from earlier edges. In that case the edge is held back until the counter returns to a reference level. The two reference levels are captured at the first command edges after reset. Command pulses too short to reach the output therefore leave their area in the counter, and a later output pulse delivers it. The latency and the minimum output pulse come to the larger of the leg's turn-on and turn-off lags, rather than their sum. Both inputs are asynchronous to the logic clock and pass through synchronisers inside the block.

All pins are plain levels, sampled on every clock. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure: the block cannot stall its input, and the output follows each cycle.

Top module: `deadtime_err_comp`

## Requirements
- R1: While reset is asserted and right after it is released, `c_out` is 0 and `err_cnt` is 0.
- R2: Each clock, the counter adds one when the synchronised command is 1 and the synchronised feedback is 0. It subtracts one when the command is 0 and the feedback is 1. It holds when the two are equal.
- R3: The counter is a two's-complement value of `CNT_W` bits (16 by default). It saturates at +32767 and at -32768 and never wraps.
- R4: Each input passes through `SYNC_STAGES` flip-flops (2 by default). On the first rising command edge after reset, `c_out` rises on the third clock after the raw input rises. The counter value at that point is captured as the turn-on reference.
- R5: On the first falling command edge after reset, `c_out` falls with the same three-clock latency. The counter value is captured as the turn-off reference.
- R6: On a later rising command edge with the counter below the turn-on reference, `c_out` stays low until the counter reaches that reference. This situation arises when the turn-off lag exceeds the turn-on lag, and the counter then rests at a negative value.
- R7: On a later rising command edge with the counter at or above the turn-on reference, `c_out` rises with the three-clock latency. When the turn-on lag exceeds the turn-off lag, the counter rests at a positive value.
- R8: On a later falling command edge with the counter above the turn-off reference, `c_out` stays high until the counter has come down to that reference. Because the counter only falls while the feedback is high, `c_out` stays high for as long as the leg output has not switched.
- R9: On a later falling command edge with the counter at or below the turn-off reference, `c_out` falls with the three-clock latency.
- R10: A new command edge that arrives while an earlier edge is held cancels the held release, and the rule for the new edge applies instead.
- R11: Command pulses too short to appear at the output keep their area in the counter. After a following normal pulse and an idle period, the counter rests at the same value as after normal pulses alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_raw | input | 1 | Commanded switching waveform, asynchronous |
| b_raw | input | 1 | Detected leg-output switching state, asynchronous |
| c_out | output | 1 | Compensated command to the dead-time stage |
| err_cnt | output | CNT_W | Signed integrated voltage error |

## Verification
The hardest state to reach from the ports is a turn-off edge held high while the leg never switches, together with the counter pinned at either limit. A leg model with unequal lags never produces either of these. The bench therefore overrides the model's feedback with a forced level. This keeps the counter climbing past the turn-off reference, lets a new rising edge arrive during the hold, and drives the counter into both rails. When the override is released, the model's real feedback resumes, and the bench expects the counter to return to its earlier rest value.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  // Edge release state of the compensated command
  typedef enum logic [1:0] {
    REL_NONE = 2'd0,
    REL_ON   = 2'd1,
    REL_OFF  = 2'd2
  } rel_e;
endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dtc_err_cnt.sv
module dtc_err_cnt #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up,
  input  logic                dn,
  output logic signed [W-1:0] cnt
);
  localparam logic signed [W-1:0] CMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] CMIN = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (up && (cnt != CMAX))  cnt <= cnt + W'(1);
    else if (dn && (cnt != CMIN))  cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/dtc_edge_ctl.sv
module dtc_edge_ctl
  import dtc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_s,
  input  logic signed [W-1:0] cnt,
  output logic                c_q,
  output logic                rise,
  output logic                fall,
  output logic                x_valid,
  output logic                y_valid,
  output logic signed [W-1:0] x_ref,
  output logic signed [W-1:0] y_ref
);
  logic a_d;
  rel_e rel_q;

  assign rise = a_s & ~a_d;
  assign fall = ~a_s & a_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_d     <= 1'b0;
      c_q     <= 1'b0;
      rel_q   <= REL_NONE;
      x_valid <= 1'b0;
      y_valid <= 1'b0;
      x_ref   <= '0;
      y_ref   <= '0;
    end else begin
      a_d <= a_s;
      if (rise) begin
        if (!x_valid) begin
          x_valid <= 1'b1;
          x_ref   <= cnt;
          c_q     <= 1'b1;
          rel_q   <= REL_NONE;
        end else if (cnt < x_ref) begin
          c_q   <= 1'b0;
          rel_q <= REL_ON;
        end else begin
          c_q   <= 1'b1;
          rel_q <= REL_NONE;
        end
      end else if (fall) begin
        if (!y_valid) begin
          y_valid <= 1'b1;
          y_ref   <= cnt;
          c_q     <= 1'b0;
          rel_q   <= REL_NONE;
        end else if (cnt > y_ref) begin
          c_q   <= 1'b1;
          rel_q <= REL_OFF;
        end else begin
          c_q   <= 1'b0;
          rel_q <= REL_NONE;
        end
      end else begin
        case (rel_q)
          REL_ON: if (cnt >= x_ref) begin
            c_q   <= 1'b1;
            rel_q <= REL_NONE;
          end
          REL_OFF: if (cnt <= y_ref) begin
            c_q   <= 1'b0;
            rel_q <= REL_NONE;
          end
          default: rel_q <= REL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/deadtime_err_comp.sv
module deadtime_err_comp #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_raw,
  input  logic                    b_raw,
  output logic                    c_out,
  output logic signed [CNT_W-1:0] err_cnt
);
  logic [1:0]             sync_q;
  logic                   a_s;
  logic                   b_s;
  logic                   rise;
  logic                   fall;
  logic                   x_valid;
  logic                   y_valid;
  logic signed [CNT_W-1:0] x_ref;
  logic signed [CNT_W-1:0] y_ref;

  dtc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({b_raw, a_raw}),
    .q     (sync_q)
  );

  assign a_s = sync_q[0];
  assign b_s = sync_q[1];

  dtc_err_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .up    (a_s & ~b_s),
    .dn    (~a_s & b_s),
    .cnt   (err_cnt)
  );

  dtc_edge_ctl #(.W(CNT_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_s     (a_s),
    .cnt     (err_cnt),
    .c_q     (c_out),
    .rise    (rise),
    .fall    (fall),
    .x_valid (x_valid),
    .y_valid (y_valid),
    .x_ref   (x_ref),
    .y_ref   (y_ref)
  );
endmodule

// File: rtl/dtc_checks.sv
module dtc_checks #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                a_s,
  input logic                b_s,
  input logic                rise,
  input logic                fall,
  input logic                c_out,
  input logic                x_valid,
  input logic                y_valid,
  input logic signed [W-1:0] x_ref,
  input logic signed [W-1:0] y_ref,
  input logic signed [W-1:0] cnt
);
  localparam logic signed [W-1:0] CMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] CMIN = {1'b1, {(W-1){1'b0}}};

  // R2: the counter moves by at most one per clock
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + W'(1)) || (cnt == $past(cnt) - W'(1)));

  // R2: equal command and feedback freeze the counter
  a_r2_hold_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (a_s == b_s) |=> $stable(cnt));

  // R3: no wrap from the top rail to the bottom
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == CMAX) |-> (cnt != CMIN));

  // R3: no wrap from the bottom rail to the top
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == CMIN) |-> (cnt != CMAX));

  // R4: the first rising edge passes straight through
  a_r4_first_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !x_valid) |=> (c_out && x_valid));

  // R5: the first falling edge passes straight through
  a_r5_first_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !y_valid) |=> (!c_out && y_valid));

  // R6: a held turn-on stays low while the counter is short of the reference
  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && a_s && !rise && !c_out && (cnt < x_ref)) |=> !c_out);

  // R8: a held turn-off stays high while the counter exceeds the reference
  a_r8_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !a_s && c_out && (cnt > y_ref)) |=> c_out);
endmodule

bind deadtime_err_comp dtc_checks #(.W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_s     (a_s),
  .b_s     (b_s),
  .rise    (rise),
  .fall    (fall),
  .c_out   (c_out),
  .x_valid (x_valid),
  .y_valid (y_valid),
  .x_ref   (x_ref),
  .y_ref   (y_ref),
  .cnt     (err_cnt)
);

// File: tb/sim_deadtime_err_comp.sv
module sim_deadtime_err_comp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_raw = 1'b0;
  logic b_raw = 1'b0;
  logic c_out;
  logic signed [15:0] err_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  deadtime_err_comp u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_raw   (a_raw),
    .b_raw   (b_raw),
    .c_out   (c_out),
    .err_cnt (err_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Leg model: output follows C with separate turn-on / turn-off lags
  int lag_on = 6;
  int lag_off = 14;
  bit c_hist [64];
  bit b_pl = 1'b0;
  bit force_en = 1'b0;
  bit force_val = 1'b0;

  always @(negedge clk) begin
    for (int i = 63; i > 0; i--) c_hist[i] = c_hist[i-1];
    c_hist[0] = c_out;
    if (!b_pl && c_hist[lag_on-1]) b_pl = 1'b1;
    else if (b_pl && !c_hist[lag_off-1]) b_pl = 1'b0;
    b_raw = force_en ? force_val : b_pl;
  end

  // Behavioural reference: pipelines of the raw inputs, integer counter
  bit m_a0, m_a1, m_ad, m_b0, m_b1, m_c, m_xv, m_yv;
  int m_cnt, m_x, m_y, m_pend;

  always @(posedge clk or negedge rst_n) begin : mstep
    bit r, f;
    int nc;
    if (!rst_n) begin
      m_a0 = 0; m_a1 = 0; m_ad = 0; m_b0 = 0; m_b1 = 0; m_c = 0;
      m_xv = 0; m_yv = 0; m_cnt = 0; m_x = 0; m_y = 0; m_pend = 0;
    end else begin
      r = m_a1 && !m_ad;
      f = !m_a1 && m_ad;
      nc = m_cnt;
      if (m_a1 && !m_b1 && m_cnt < 32767) nc = m_cnt + 1;
      else if (!m_a1 && m_b1 && m_cnt > -32768) nc = m_cnt - 1;
      if (r) begin
        if (!m_xv) begin m_xv = 1; m_x = m_cnt; m_c = 1; m_pend = 0; end
        else if (m_cnt < m_x) begin m_c = 0; m_pend = 1; end
        else begin m_c = 1; m_pend = 0; end
      end else if (f) begin
        if (!m_yv) begin m_yv = 1; m_y = m_cnt; m_c = 0; m_pend = 0; end
        else if (m_cnt > m_y) begin m_c = 1; m_pend = 2; end
        else begin m_c = 0; m_pend = 0; end
      end else if (m_pend == 1 && m_cnt >= m_x) begin
        m_c = 1; m_pend = 0;
      end else if (m_pend == 2 && m_cnt <= m_y) begin
        m_c = 0; m_pend = 0;
      end
      m_cnt = nc;
      m_ad = m_a1; m_a1 = m_a0; m_a0 = a_raw;
      m_b1 = m_b0; m_b0 = b_raw;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(c_out == m_c, "R4/R5/R6/R7/R8/R9/R10/R11 c_out vs model", int'(c_out), int'(m_c));
      chk(int'(err_cnt) == m_cnt, "R2/R3 err_cnt vs model", int'(err_cnt), m_cnt);
    end
  end

  task automatic normal_pulse(input int hi, input int lo);
    a_raw = 1'b1; wait_n(hi);
    a_raw = 1'b0; wait_n(lo);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int r0, v;
    // ---------- phase 1: turn-off lag longer ----------
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    chk(c_out == 0, "R1 c_out after reset", int'(c_out), 0);
    chk(err_cnt == 0, "R1 err_cnt after reset", int'(err_cnt), 0);

    a_raw = 1'b1; wait_n(2);
    chk(c_out == 0, "R4 c_out before latency", int'(c_out), 0);
    wait_n(1);
    chk(c_out == 1, "R4 first rise immediate", int'(c_out), 1);
    chk(err_cnt == 1, "R4 count starts", int'(err_cnt), 1);
    wait_n(57);
    a_raw = 1'b0; wait_n(2);
    chk(c_out == 1, "R5 c_out before latency", int'(c_out), 1);
    wait_n(1);
    chk(c_out == 0, "R5 first fall immediate", int'(c_out), 0);
    wait_n(77);

    a_raw = 1'b1; wait_n(3);
    chk(c_out == 0, "R6 later rise held", int'(c_out), 0);
    wait_n(57);
    a_raw = 1'b0; wait_n(2);
    chk(c_out == 1, "R9 high before fall", int'(c_out), 1);
    wait_n(1);
    chk(c_out == 0, "R9 later fall immediate", int'(c_out), 0);
    wait_n(77);

    normal_pulse(60, 80);
    normal_pulse(60, 80);
    r0 = int'(err_cnt);
    chk(r0 < 0, "R6 rest value negative", r0, -1);

    for (int k = 0; k < 5; k++) normal_pulse(3, 20);
    normal_pulse(60, 180);
    v = int'(err_cnt);
    chk(v >= r0 - 1 && v <= r0 + 1, "R11 short-pulse area recovered", v, r0);

    force_val = 1'b0; force_en = 1'b1;
    a_raw = 1'b1; wait_n(40);
    a_raw = 1'b0; wait_n(50);
    chk(c_out == 1, "R8 held high while leg idle", int'(c_out), 1);
    a_raw = 1'b1; wait_n(10);
    chk(c_out == 1, "R10 new rise during hold", int'(c_out), 1);
    a_raw = 1'b0; wait_n(10);
    chk(c_out == 1, "R8 held high again", int'(c_out), 1);
    force_en = 1'b0; wait_n(200);
    chk(c_out == 0, "R8 released after feedback", int'(c_out), 0);
    v = int'(err_cnt);
    chk(v >= r0 - 1 && v <= r0 + 1, "R8 rest after release", v, r0);

    force_en = 1'b1; force_val = 1'b0;
    a_raw = 1'b1; wait_n(10); v = int'(err_cnt); wait_n(10);
    chk(int'(err_cnt) == v + 10, "R2 count up", int'(err_cnt), v + 10);
    a_raw = 1'b0; force_val = 1'b1; wait_n(10); v = int'(err_cnt); wait_n(10);
    chk(int'(err_cnt) == v - 10, "R2 count down", int'(err_cnt), v - 10);
    a_raw = 1'b1; wait_n(10); v = int'(err_cnt); wait_n(10);
    chk(int'(err_cnt) == v, "R2 hold both high", int'(err_cnt), v);
    a_raw = 1'b0; force_val = 1'b0; wait_n(10); v = int'(err_cnt); wait_n(10);
    chk(int'(err_cnt) == v, "R2 hold both low", int'(err_cnt), v);

    a_raw = 1'b1; wait_n(33000);
    chk(int'(err_cnt) == 32767, "R3 top rail", int'(err_cnt), 32767);
    wait_n(20);
    chk(int'(err_cnt) == 32767, "R3 top rail kept", int'(err_cnt), 32767);
    a_raw = 1'b0; force_val = 1'b1; wait_n(66000);
    chk(int'(err_cnt) == -32768, "R3 bottom rail", int'(err_cnt), -32768);
    wait_n(20);
    chk(int'(err_cnt) == -32768, "R3 bottom rail kept", int'(err_cnt), -32768);

    // ---------- phase 2: turn-on lag longer ----------
    rst_n = 1'b0; force_en = 1'b0; a_raw = 1'b0;
    lag_on = 14; lag_off = 6;
    wait_n(80);
    rst_n = 1'b1;
    wait_n(2);
    chk(c_out == 0 && err_cnt == 0, "R1 second reset", int'(err_cnt), 0);
    normal_pulse(60, 80);
    normal_pulse(60, 80);
    v = int'(err_cnt);
    chk(v > 0, "R7 rest value positive", v, 1);
    a_raw = 1'b1; wait_n(3);
    chk(c_out == 1, "R7 later rise immediate", int'(c_out), 1);
    wait_n(57);
    a_raw = 1'b0; wait_n(3);
    chk(c_out == 1, "R8 later fall held", int'(c_out), 1);
    wait_n(77);
    chk(c_out == 0, "R8 fall eventually released", int'(c_out), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule